// File: doc/BRIEF.md
# BCD Rate Multiplier

This block thins a clock into a pulse train. A decade counter steps through ten states. A four-bit BCD rate code picks a subset of those states. In each clock cycle where the counter sits in a picked state and is allowed to advance, the rate output is high for that cycle. Over any ten advancing cycles, the number of output pulses equals the rate code. The state subsets for the four code bits are spread across the decade, so the pulses are distributed rather than bunched.

Several copies can be chained. In add mode, the carry output of a faster digit enables the next slower digit, and the slower digit's rate output is merged through the faster digit's cascade input. The merged train then carries 10·d1 + d2 pulses per hundred clocks. In multiply mode, the first digit's rate output becomes the advance enable of the second digit, and the second digit delivers d1·d2 pulses per hundred clocks.

Strobe, clear, preset-to-nine and inhibit inputs give control over the output path and over the counter.

Top module: `bcd_rate_mult`

## Requirements
- R1: After synchronous reset the counter is 0: `nine_o`=0, `carry_o`=1, and with a rate code of 0 `rate_o`=0 and `rate_n_o`=1.
- R2: With no control input active, the counter advances by one per clock, wrapping 9 to 0, and `nine_o` is high in exactly one of every ten cycles.
- R3: Over ten advancing cycles, `rate_o` is high in exactly as many cycles as the BCD value (0 to 9) on `rate_i`.
- R4: `rate_o` pulses at fixed counter states. Bit 0 (weight 1) selects state 3. Bit 1 (weight 2) selects states 1 and 5. Bit 2 (weight 4) selects states 0, 2, 4 and 6. Bit 3 (weight 8) selects states 0, 1, 2, 4, 5, 6, 7 and 8. The selected set is the union of these subsets, and state 9 never pulses.
- R5: `clear_i` sets the counter to 0 at the next clock edge and wins over `preset9_i`.
- R6: `preset9_i` (with clear low) sets the counter to 9 at the next clock edge, and the following advance wraps it to 0.
- R7: While `strobe_i` is high, `rate_o`=0 and `rate_n_o`=1 regardless of cascade, and the counter keeps advancing.
- R8: While `cascade_i` is high and the strobe is low, `rate_o` is 1.
- R9: While `inhibit_i` is high, the counter holds its value, no rate pulse is produced, and `carry_o` is 1.
- R10: `carry_o` is 0 exactly when the counter holds 9 and `inhibit_i` is low.
- R11: `rate_n_o` is always the complement of `rate_o`.
- R12: In an add-mode chain of two digits, the merged output gives 10·d1 + d2 pulses per 100 clocks after both digits are cleared.
- R13: In a multiply-mode chain of two digits, the second digit gives d1·d2 pulses per 100 clocks after both digits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_i | input | 4 | BCD rate code |
| inhibit_i | input | 1 | Carry in; high stops counting and pulses |
| strobe_i | input | 1 | High forces the rate output low |
| cascade_i | input | 1 | Merged into the rate output (OR) |
| clear_i | input | 1 | Synchronous clear of the counter |
| preset9_i | input | 1 | Synchronous load of nine |
| rate_o | output | 1 | Rate pulse output |
| rate_n_o | output | 1 | Complemented rate output |
| nine_o | output | 1 | Counter holds nine |
| carry_o | output | 1 | Carry out to the next digit's inhibit |

## Verification
A counter that skips or repeats a state shifts the pulse pattern measured from a clear. It shows up within ten cycles as a wrong bit in the per-state pattern, and as `nine_o` rising in the wrong cycle. A wrong state-to-bit assignment changes the pattern for single-bit codes, and an overlap between subsets shows as a pulse count below the code value. Errors in chaining only appear over the hundred-cycle windows of the add and multiply chains. There, a misplaced carry or a missing inhibit gate gives a pulse total that differs from 10·d1+d2 or d1·d2.

// File: rtl/rm_pkg.sv
package rm_pkg;

    localparam int RATE_W   = 4;
    localparam int MODULUS  = 10;
    localparam int CNT_W    = $clog2(MODULUS);
    localparam int STATES   = 2 ** CNT_W;

    // states used by the individual weights
    localparam int UNIT_STATE = 3;
    localparam int PAIR_LO    = 1;
    localparam int PAIR_HI    = 5;
    localparam int QUAD_LIMIT = 7;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [STATES-1:0] state_mask_t;

    typedef enum logic [1:0] {
        ACT_COUNT  = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_PRESET = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic sel;
        logic enable;
        logic strobe;
        logic cascade;
    } rate_path_t;

    function automatic state_mask_t weight_mask(input int bit_idx);
        state_mask_t m;
        m = '0;
        for (int s = 0; s < STATES; s++) begin
            case (bit_idx)
                0:       m[s] = (s == UNIT_STATE);
                1:       m[s] = (s == PAIR_LO) || (s == PAIR_HI);
                2:       m[s] = (s < QUAD_LIMIT) && ((s % 2) == 0);
                default: m[s] = (s < MODULUS - 1) && (s != UNIT_STATE);
            endcase
        end
        return m;
    endfunction

    function automatic cnt_t next_count(input cnt_t c);
        return (c == cnt_t'(MODULUS - 1)) ? '0 : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/rm_ctrl_decode.sv
module rm_ctrl_decode
    import rm_pkg::*;
(
    input  logic     clear_i,
    input  logic     preset9_i,
    input  logic     inhibit_i,
    output cnt_act_e act_o
);
    always_comb begin
        if (clear_i)        act_o = ACT_CLEAR;
        else if (preset9_i) act_o = ACT_PRESET;
        else if (inhibit_i) act_o = ACT_HOLD;
        else                act_o = ACT_COUNT;
    end
endmodule

// File: rtl/rm_decade_counter.sv
module rm_decade_counter
    import rm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_act_e act_i,
    output cnt_t     cnt_o,
    output logic     nine_o
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act_i)
                ACT_CLEAR:  cnt_q <= '0;
                ACT_PRESET: cnt_q <= cnt_t'(MODULUS - 1);
                ACT_HOLD:   cnt_q <= cnt_q;
                default:    cnt_q <= next_count(cnt_q);
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign nine_o = (cnt_q == cnt_t'(MODULUS - 1));

    // R2
    count_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_COUNT) |=> (cnt_q == next_count($past(cnt_q))));
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_CLEAR) |=> (cnt_q == '0));
    // R6
    preset_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_PRESET) |=> (cnt_q == cnt_t'(MODULUS - 1)));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_HOLD) |=> $stable(cnt_q));
endmodule

// File: rtl/rm_rate_select.sv
module rm_rate_select
    import rm_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    input  cnt_t              cnt_i,
    output logic              sel_o
);
    logic [RATE_W-1:0] hit;

    for (genvar b = 0; b < RATE_W; b++) begin : g_weight
        localparam state_mask_t MASK = weight_mask(b);
        assign hit[b] = rate_i[b] & MASK[cnt_i];
    end

    assign sel_o = |hit;

    // R4
    last_state_quiet_chk: assert final (!(cnt_i == cnt_t'(MODULUS - 1)) || !sel_o);
endmodule

// File: rtl/rm_output_stage.sv
module rm_output_stage
    import rm_pkg::*;
(
    input  rate_path_t path_i,
    output logic       rate_o,
    output logic       rate_n_o
);
    logic pulse;

    always_comb begin
        pulse = (path_i.sel & path_i.enable) | path_i.cascade;
        if (path_i.strobe) pulse = 1'b0;
    end

    assign rate_o   = pulse;
    assign rate_n_o = ~pulse;
endmodule

// File: rtl/bcd_rate_mult.sv
module bcd_rate_mult
    import rm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rate_i,
    input  logic       inhibit_i,
    input  logic       strobe_i,
    input  logic       cascade_i,
    input  logic       clear_i,
    input  logic       preset9_i,
    output logic       rate_o,
    output logic       rate_n_o,
    output logic       nine_o,
    output logic       carry_o
);
    cnt_act_e   act;
    cnt_t       cnt;
    logic       nine;
    logic       sel;
    rate_path_t path;

    rm_ctrl_decode u_dec (
        .clear_i   (clear_i),
        .preset9_i (preset9_i),
        .inhibit_i (inhibit_i),
        .act_o     (act)
    );

    rm_decade_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .cnt_o  (cnt),
        .nine_o (nine)
    );

    rm_rate_select u_sel (
        .rate_i (rate_i),
        .cnt_i  (cnt),
        .sel_o  (sel)
    );

    always_comb begin
        path.sel     = sel;
        path.enable  = ~inhibit_i;
        path.strobe  = strobe_i;
        path.cascade = cascade_i;
    end

    rm_output_stage u_out (
        .path_i   (path),
        .rate_o   (rate_o),
        .rate_n_o (rate_n_o)
    );

    assign nine_o  = nine;
    assign carry_o = inhibit_i | ~nine;

    // R7
    strobe_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_i |-> (!rate_o && rate_n_o));
    // R8
    cascade_chk: assert property (@(posedge clk) disable iff (rst)
        (cascade_i && !strobe_i) |-> rate_o);
    // R10
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (nine_o && !inhibit_i) |-> !carry_o);
    // R11
    compl_chk: assert property (@(posedge clk) disable iff (rst)
        rate_o != rate_n_o);
    // R9
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit_i && !cascade_i) |-> (!rate_o && carry_o));
endmodule

// File: tb/sim_bcd_rate_mult.sv
`timescale 1ns/1ps
module sim_bcd_rate_mult;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic [3:0] rate_i = '0;
    logic       inhibit_i = 0, strobe_i = 0, cascade_i = 0, clear_i = 0, preset9_i = 0;
    logic       rate_o, rate_n_o, nine_o, carry_o;

    int errors = 0;
    int checks = 0;

    bcd_rate_mult u0 (
        .clk(clk), .rst(rst), .rate_i(rate_i), .inhibit_i(inhibit_i),
        .strobe_i(strobe_i), .cascade_i(cascade_i), .clear_i(clear_i),
        .preset9_i(preset9_i), .rate_o(rate_o), .rate_n_o(rate_n_o),
        .nine_o(nine_o), .carry_o(carry_o)
    );

    // add-mode chain: a1 fast digit, a2 slow digit
    logic [3:0] a1_rate = '0, a2_rate = '0;
    logic       a_clear = 0;
    logic       a1_out, a1_out_n, a1_nine, a1_carry;
    logic       a2_out, a2_out_n, a2_nine, a2_carry;

    bcd_rate_mult u_a1 (
        .clk(clk), .rst(rst), .rate_i(a1_rate), .inhibit_i(1'b0),
        .strobe_i(1'b0), .cascade_i(a2_out), .clear_i(a_clear),
        .preset9_i(1'b0), .rate_o(a1_out), .rate_n_o(a1_out_n),
        .nine_o(a1_nine), .carry_o(a1_carry)
    );
    bcd_rate_mult u_a2 (
        .clk(clk), .rst(rst), .rate_i(a2_rate), .inhibit_i(a1_carry),
        .strobe_i(1'b0), .cascade_i(1'b0), .clear_i(a_clear),
        .preset9_i(1'b0), .rate_o(a2_out), .rate_n_o(a2_out_n),
        .nine_o(a2_nine), .carry_o(a2_carry)
    );

    // multiply-mode chain: m1 output enables m2
    logic [3:0] m1_rate = '0, m2_rate = '0;
    logic       m_clear = 0;
    logic       m1_out, m1_out_n, m1_nine, m1_carry;
    logic       m2_out, m2_out_n, m2_nine, m2_carry;

    bcd_rate_mult u_m1 (
        .clk(clk), .rst(rst), .rate_i(m1_rate), .inhibit_i(1'b0),
        .strobe_i(1'b0), .cascade_i(1'b0), .clear_i(m_clear),
        .preset9_i(1'b0), .rate_o(m1_out), .rate_n_o(m1_out_n),
        .nine_o(m1_nine), .carry_o(m1_carry)
    );
    bcd_rate_mult u_m2 (
        .clk(clk), .rst(rst), .rate_i(m2_rate), .inhibit_i(m1_out_n),
        .strobe_i(1'b0), .cascade_i(1'b0), .clear_i(m_clear),
        .preset9_i(1'b0), .rate_o(m2_out), .rate_n_o(m2_out_n),
        .nine_o(m2_nine), .carry_o(m2_carry)
    );

    // {code, pulse pattern by counter state 9..0} per R4
    localparam logic [13:0] VEC [10] = '{
        {4'd0, 10'h000}, {4'd1, 10'h008}, {4'd2, 10'h022}, {4'd3, 10'h02A},
        {4'd4, 10'h055}, {4'd5, 10'h05D}, {4'd6, 10'h077}, {4'd7, 10'h07F},
        {4'd8, 10'h1F7}, {4'd9, 10'h1FF}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        cyc();
        clear_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) cyc();
        rst = 1'b0;
        #1;
        // R1
        chk(nine_o == 1'b0, "R1 nine", nine_o, 0);
        chk(carry_o == 1'b1, "R1 carry", carry_o, 1);
        chk(rate_o == 1'b0 && rate_n_o == 1'b1, "R1 rate", rate_o, 0);

        // table walk: R2 R3 R4 R11
        foreach (VEC[i]) begin
            logic [9:0] pat;
            logic [9:0] nines;
            int         cmpl_bad;
            pat = '0;
            nines = '0;
            cmpl_bad = 0;
            do_clear();
            rate_i = VEC[i][13:10];
            for (int k = 0; k < 10; k++) begin
                #1;
                pat[k]   = rate_o;
                nines[k] = nine_o;
                if (rate_o == rate_n_o) cmpl_bad++;
                cyc();
            end
            chk(pat == VEC[i][9:0], "R4 pattern", int'(pat), int'(VEC[i][9:0]));
            chk($countones(pat) == int'(VEC[i][13:10]), "R3 count",
                $countones(pat), int'(VEC[i][13:10]));
            chk(nines == 10'h200, "R2 nine once", int'(nines), 'h200);
            chk(cmpl_bad == 0, "R11 complement", cmpl_bad, 0);
        end

        // R6 preset and wrap, R10 carry
        rate_i = 4'd4;
        preset9_i = 1'b1;
        cyc();
        preset9_i = 1'b0;
        #1;
        chk(nine_o == 1'b1, "R6 preset nine", nine_o, 1);
        chk(carry_o == 1'b0, "R10 carry low at nine", carry_o, 0);
        cyc();
        #1;
        chk(nine_o == 1'b0 && rate_o == 1'b1, "R6 wrap to zero", rate_o, 1);

        // R5 clear beats preset
        preset9_i = 1'b1;
        cyc();
        clear_i = 1'b1;
        cyc();
        clear_i = 1'b0;
        preset9_i = 1'b0;
        #1;
        chk(nine_o == 1'b0 && rate_o == 1'b1, "R5 clear priority", nine_o, 0);

        // R9 inhibit holds the counter at state 0
        do_clear();
        inhibit_i = 1'b1;
        #1;
        chk(rate_o == 1'b0, "R9 no pulse", rate_o, 0);
        chk(carry_o == 1'b1, "R9 carry high", carry_o, 1);
        repeat (3) cyc();
        inhibit_i = 1'b0;
        #1;
        chk(rate_o == 1'b1, "R9 counter held", rate_o, 1);
        preset9_i = 1'b1;
        cyc();
        preset9_i = 1'b0;
        inhibit_i = 1'b1;
        #1;
        chk(carry_o == 1'b1, "R10 inhibit forces carry", carry_o, 1);
        inhibit_i = 1'b0;

        // R7 strobe blocks output, counter keeps running
        do_clear();
        rate_i = 4'd1;
        strobe_i = 1'b1;
        cascade_i = 1'b1;
        #1;
        chk(rate_o == 1'b0 && rate_n_o == 1'b1, "R7 strobe over cascade", rate_o, 0);
        cascade_i = 1'b0;
        repeat (3) cyc();
        #1;
        chk(rate_o == 1'b0, "R7 strobe at state 3", rate_o, 0);
        strobe_i = 1'b0;
        #1;
        chk(rate_o == 1'b1, "R7 counter advanced", rate_o, 1);

        // R8 cascade merge
        rate_i = 4'd0;
        cascade_i = 1'b1;
        #1;
        chk(rate_o == 1'b1 && rate_n_o == 1'b0, "R8 cascade", rate_o, 1);
        cascade_i = 1'b0;

        // R12 add mode
        for (int t = 0; t < 2; t++) begin
            int n;
            int exp;
            a1_rate = (t == 0) ? 4'd3 : 4'd9;
            a2_rate = (t == 0) ? 4'd7 : 4'd9;
            exp = 10 * int'(a1_rate) + int'(a2_rate);
            a_clear = 1'b1;
            cyc();
            a_clear = 1'b0;
            n = 0;
            for (int k = 0; k < 100; k++) begin
                #1;
                if (a1_out) n++;
                cyc();
            end
            chk(n == exp, "R12 add chain", n, exp);
        end

        // R13 multiply mode
        for (int t = 0; t < 2; t++) begin
            int n;
            int exp;
            m1_rate = (t == 0) ? 4'd9 : 4'd5;
            m2_rate = (t == 0) ? 4'd4 : 4'd5;
            exp = int'(m1_rate) * int'(m2_rate);
            m_clear = 1'b1;
            cyc();
            m_clear = 1'b0;
            n = 0;
            for (int k = 0; k < 100; k++) begin
                #1;
                if (m2_out) n++;
                cyc();
            end
            chk(n == exp, "R13 multiply chain", n, exp);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule